// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block gathers the interrupt events of a multi-channel DMA controller. Each channel engine pulses one of four event lines: transfer complete, source error, destination error or configuration error. The block latches each pulse into a raw status register for its class, with one bit per channel. Software reads the raw or the masked view of each class through a simple register bus and clears events by writing ones to the raw view. The block drives one level interrupt toward the processor.

Each channel also supplies two interrupt-enable bits. The masked view of a class is the raw view gated by those enables, and the interrupt output is raised while any masked bit is set. Two plain configuration registers, the group priority word and the arbitration word, also sit in this register window and are driven out to the channel engines.

Top module: `dma_irq_aggr`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every raw and masked status bit is 0, irq is 0, and grp_prio and arb_cfg are 0.
- R2: An event pulse on channel c of a class sets bit c of that class's raw register at the next clock edge. The bit then stays set until software clears it.
- R3: The raw registers are read at offsets 0x810 (complete), 0x814 (source error), 0x818 (destination error) and 0x81C (configuration error). Channel c is at bit c, and an event in one class leaves the other classes untouched.
- R4: A bus write to a raw register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: Writing 0xFFFFFFFF to a raw register clears every channel of that class.
- R6: When a new event and a clearing write hit the same bit in the same cycle, the bit remains set.
- R7: The masked registers are read at 0x800, 0x804, 0x808 and 0x80C, in the same class order as R3. ch_irq_en[2c] gates the complete class of channel c, and ch_irq_en[2c+1] gates all three error classes of channel c. A masked bit is its raw bit ANDed with the gating enable.
- R8: irq is the OR of all masked bits of all four classes and follows the enables in the same cycle.
- R9: The group priority register at 0x824 and the arbitration register at 0x828 are written by the bus, read back and driven on grp_prio and arb_cfg from the cycle after the write. Writing zero to 0x828 returns arb_cfg to 0, the equal-priority setting.
- R10: Writes to the masked registers have no effect on any status bit. Reads of any unmapped offset, such as 0x820 or 0x830, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read access, 0 otherwise |
| evt_done | input | NUM_CH | Per-channel transfer-complete pulses |
| evt_src_err | input | NUM_CH | Per-channel source-error pulses |
| evt_dst_err | input | NUM_CH | Per-channel destination-error pulses |
| evt_cfg_err | input | NUM_CH | Per-channel configuration-error pulses |
| ch_irq_en | input | 2*NUM_CH | Per-channel enables: bit 2c for complete, bit 2c+1 for errors |
| grp_prio | output | DATA_W | Group priority word |
| arb_cfg | output | DATA_W | Arbitration word, 0 = equal priority |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses a four-channel configuration. Every channel of every class is hit on its own, which shows that the bit positions and class offsets are right and that no event leaks into another class. All sixteen clear masks are swept over a fully set register of each class, which separates true write-one-to-clear from clear-all or write-through behaviour. All 256 enable patterns are swept against fully set raw registers and against a single set error bit, and the masked views and irq are computed from the enable bits. This shows whether the complete class and the error classes are gated by the right enable bit. Directed cases cover a clear that collides with a new event, writes to the read-only masked offsets, unmapped reads and the two configuration words.

// File: rtl/dma_irq_pkg.sv
// Shared constants for the DMA interrupt aggregator.
// Assumes byte offsets relative to the block base, 32-bit word stride.
package dma_irq_pkg;
    typedef enum logic [1:0] {
        CLS_DONE = 2'd0,
        CLS_SRC  = 2'd1,
        CLS_DST  = 2'd2,
        CLS_CFG  = 2'd3
    } irq_class_e;

    localparam int unsigned NUM_CLS     = 4;
    localparam int unsigned OFF_MASKED  = 32'h800;
    localparam int unsigned OFF_RAW     = 32'h810;
    localparam int unsigned OFF_PRIO    = 32'h824;
    localparam int unsigned OFF_ARB     = 32'h828;
    localparam int unsigned WORD_BYTES  = 4;
endpackage

// File: rtl/irq_class_bank.sv
// One event class: a raw status bit per channel, set by an event pulse,
// cleared by a write-one-to-clear strobe. A new event outranks a clear.
// Assumes event pulses are synchronous to clk and one cycle wide or longer.
module irq_class_bank #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    input  logic [NUM_CH-1:0] en,
    output logic [NUM_CH-1:0] raw,
    output logic [NUM_CH-1:0] masked
);

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            // Per-channel sticky status bit with event priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    raw[c] <= 1'b0;
                else if (evt[c])
                    raw[c] <= 1'b1;
                else if (clr_we && clr_mask[c])
                    raw[c] <= 1'b0;
            end

            assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
                evt[c] |=> raw[c]);
            assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we && clr_mask[c] && !evt[c]) |=> !raw[c]);
            assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!evt[c] && !(clr_we && clr_mask[c])) |=> $stable(raw[c]));
            assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (evt[c] && clr_we && clr_mask[c]) |=> raw[c]);
        end
    endgenerate

    // Masked view: raw gated by the channel's enable.
    always_comb masked = raw & en;

endmodule

// File: rtl/irq_reg_if.sv
// Register bus slave: decodes clear strobes for the raw views, holds the
// priority and arbitration words, and muxes read data.
// Assumes one access per cycle; reads are combinational, writes land at the edge.
module irq_reg_if
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_CLS-1:0][NUM_CH-1:0] raw_all,
    input  logic [NUM_CLS-1:0][NUM_CH-1:0] masked_all,
    output logic [NUM_CLS-1:0]             clr_we,
    output logic [NUM_CH-1:0]              clr_mask,
    output logic [DATA_W-1:0]              grp_prio,
    output logic [DATA_W-1:0]              arb_cfg
);

    localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(OFF_PRIO);
    localparam logic [ADDR_W-1:0] A_ARB  = ADDR_W'(OFF_ARB);

    logic wr_en, rd_en;
    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;
    assign clr_mask = bus_wdata[NUM_CH-1:0];

    genvar k;
    generate
        for (k = 0; k < NUM_CLS; k++) begin : g_clr
            // Clear strobe for class k's raw register.
            assign clr_we[k] = wr_en &&
                (bus_addr == ADDR_W'(OFF_RAW + WORD_BYTES * k));
        end
    endgenerate

    // Configuration words written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_prio <= '0;
            arb_cfg  <= '0;
        end else if (wr_en) begin
            if (bus_addr == A_PRIO) grp_prio <= bus_wdata;
            if (bus_addr == A_ARB)  arb_cfg  <= bus_wdata;
        end
    end

    // Read data mux; unmapped offsets read as zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NUM_CLS; i++) begin
                if (bus_addr == ADDR_W'(OFF_MASKED + WORD_BYTES * i))
                    bus_rdata[NUM_CH-1:0] = masked_all[i];
                if (bus_addr == ADDR_W'(OFF_RAW + WORD_BYTES * i))
                    bus_rdata[NUM_CH-1:0] = raw_all[i];
            end
            if (bus_addr == A_PRIO) bus_rdata = grp_prio;
            if (bus_addr == A_ARB)  bus_rdata = arb_cfg;
        end
    end

    assert_arb_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_ARB) |=> (arb_cfg == $past(bus_wdata)));
    assert_prio_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_PRIO) |=> (grp_prio == $past(bus_wdata)));
    assert_one_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_we));

endmodule

// File: rtl/dma_irq_aggr.sv
// DMA interrupt status aggregator top: four event-class banks, the register
// slave, and the combined interrupt output.
// Assumes NUM_CH <= DATA_W and ADDR_W wide enough for offset 0x828.
module dma_irq_aggr
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_CH-1:0]   evt_done,
    input  logic [NUM_CH-1:0]   evt_src_err,
    input  logic [NUM_CH-1:0]   evt_dst_err,
    input  logic [NUM_CH-1:0]   evt_cfg_err,
    input  logic [2*NUM_CH-1:0] ch_irq_en,
    output logic [DATA_W-1:0]   grp_prio,
    output logic [DATA_W-1:0]   arb_cfg,
    output logic                irq
);

    logic [NUM_CLS-1:0][NUM_CH-1:0] evt_all;
    logic [NUM_CLS-1:0][NUM_CH-1:0] en_all;
    logic [NUM_CLS-1:0][NUM_CH-1:0] raw_all;
    logic [NUM_CLS-1:0][NUM_CH-1:0] masked_all;
    logic [NUM_CLS-1:0]             clr_we;
    logic [NUM_CH-1:0]              clr_mask;

    assign evt_all[CLS_DONE] = evt_done;
    assign evt_all[CLS_SRC]  = evt_src_err;
    assign evt_all[CLS_DST]  = evt_dst_err;
    assign evt_all[CLS_CFG]  = evt_cfg_err;

    // Enable fan-out: even bit gates completion, odd bit gates the errors.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            en_all[CLS_DONE][c] = ch_irq_en[2*c];
            en_all[CLS_SRC][c]  = ch_irq_en[2*c+1];
            en_all[CLS_DST][c]  = ch_irq_en[2*c+1];
            en_all[CLS_CFG][c]  = ch_irq_en[2*c+1];
        end
    end

    genvar k;
    generate
        for (k = 0; k < NUM_CLS; k++) begin : g_cls
            irq_class_bank #(.NUM_CH(NUM_CH)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt      (evt_all[k]),
                .clr_we   (clr_we[k]),
                .clr_mask (clr_mask),
                .en       (en_all[k]),
                .raw      (raw_all[k]),
                .masked   (masked_all[k])
            );
        end
    endgenerate

    irq_reg_if #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .raw_all    (raw_all),
        .masked_all (masked_all),
        .clr_we     (clr_we),
        .clr_mask   (clr_mask),
        .grp_prio   (grp_prio),
        .arb_cfg    (arb_cfg)
    );

    // Combined interrupt: any masked bit of any class.
    assign irq = |masked_all;

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|raw_all) |-> !irq);
    assert_irq_ch0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_all[CLS_DONE][0] && ch_irq_en[0]) |-> irq);
    assert_masked_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_MASKED) && !(|evt_all))
            |=> $stable(raw_all));

endmodule

// File: tb/sim_dma_irq_aggr.sv
module sim_dma_irq_aggr;
    localparam int NCH = 4;
    localparam int AW  = 12;
    localparam int DW  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [NCH-1:0]  evt [4];
    logic [2*NCH-1:0] ch_irq_en = '0;
    logic [DW-1:0]   grp_prio, arb_cfg;
    logic            irq;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    initial for (int k = 0; k < 4; k++) evt[k] = '0;

    dma_irq_aggr #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_done(evt[0]), .evt_src_err(evt[1]), .evt_dst_err(evt[2]),
        .evt_cfg_err(evt[3]), .ch_irq_en(ch_irq_en), .grp_prio(grp_prio),
        .arb_cfg(arb_cfg), .irq(irq)
    );

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(int k, logic [NCH-1:0] m);
        @(negedge clk);
        evt[k] = m;
        @(negedge clk);
        evt[k] = '0;
    endtask

    function automatic logic [AW-1:0] raw_a(int k);
        return AW'(12'h810 + 4 * k);
    endfunction
    function automatic logic [AW-1:0] msk_a(int k);
        return AW'(12'h800 + 4 * k);
    endfunction

    task automatic clear_all();
        for (int k = 0; k < 4; k++) wr(raw_a(k), 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 4; k++) begin
            rd(raw_a(k), d); chk("R1 raw", d, 0);
            rd(msk_a(k), d); chk("R1 masked", d, 0);
        end
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 prio", grp_prio, 0);
        chk("R1 arb", arb_cfg, 0);

        // R2/R3: each class, each channel alone; R4 single-bit clear
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < NCH; c++) begin
                pulse(k, NCH'(1 << c));
                repeat (3) @(negedge clk);
                for (int j = 0; j < 4; j++) begin
                    rd(raw_a(j), d);
                    chk(j == k ? "R2 R3 raw set" : "R3 other class", d,
                        j == k ? (32'd1 << c) : 32'd0);
                end
                wr(raw_a(k), 32'd1 << c);
                rd(raw_a(k), d); chk("R4 single clear", d, 0);
            end
        end

        // R4/R5: clear mask sweep per class
        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 16; m++) begin
                pulse(k, 4'hF);
                wr(raw_a(k), DW'(m));
                rd(raw_a(k), d);
                chk(m == 15 ? "R5 clear all lanes" : "R4 w1c mask", d, DW'(~m & 15));
                wr(raw_a(k), 32'hFFFF_FFFF);
                rd(raw_a(k), d); chk("R5 all ones", d, 0);
            end
        end

        // R6: event and clear collide on ch0; ch1 clears
        pulse(0, 4'b0011);
        @(negedge clk);
        evt[0] = 4'b0001;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = raw_a(0); bus_wdata = 32'h3;
        @(negedge clk);
        evt[0] = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(raw_a(0), d); chk("R6 event wins", d, 32'h1);
        clear_all();

        // R7/R8: enable sweep with all raw bits set
        for (int k = 0; k < 4; k++) pulse(k, 4'hF);
        for (int e = 0; e < 256; e++) begin
            logic [DW-1:0] ed, ee;
            ed = '0; ee = '0;
            for (int c = 0; c < NCH; c++) begin
                ed[c] = e[2*c];
                ee[c] = e[2*c+1];
            end
            @(negedge clk);
            ch_irq_en = 8'(e);
            rd(msk_a(0), d); chk("R7 masked done", d, ed);
            for (int k = 1; k < 4; k++) begin
                rd(msk_a(k), d); chk("R7 masked err", d, ee);
            end
            chk("R8 irq all set", {31'b0, irq}, {31'b0, e != 0});
        end
        clear_all();

        // R8: single cfg error on ch2
        pulse(3, 4'b0100);
        for (int e = 0; e < 256; e++) begin
            @(negedge clk);
            ch_irq_en = 8'(e);
            #1 chk("R8 irq single", {31'b0, irq}, {31'b0, e[5]});
        end
        ch_irq_en = 8'hFF;
        clear_all();
        @(negedge clk);
        #1 chk("R8 irq after clear", {31'b0, irq}, 0);

        // R9: configuration words
        wr(12'h824, 32'hA5A5_0003);
        chk("R9 prio port", grp_prio, 32'hA5A5_0003);
        rd(12'h824, d); chk("R9 prio read", d, 32'hA5A5_0003);
        wr(12'h828, 32'h0000_00F1);
        chk("R9 arb port", arb_cfg, 32'hF1);
        rd(12'h828, d); chk("R9 arb read", d, 32'hF1);
        wr(12'h828, 32'h0);
        chk("R9 arb zero", arb_cfg, 0);
        chk("R9 prio kept", grp_prio, 32'hA5A5_0003);

        // R10: masked writes ignored, unmapped reads zero
        for (int k = 0; k < 4; k++) pulse(k, 4'hF);
        for (int k = 0; k < 4; k++) wr(msk_a(k), 32'hFFFF_FFFF);
        for (int k = 0; k < 4; k++) begin
            rd(raw_a(k), d); chk("R10 masked write ignored", d, 32'hF);
        end
        rd(12'h820, d); chk("R10 unmapped 0x820", d, 0);
        rd(12'h830, d); chk("R10 unmapped 0x830", d, 0);
        rd(12'h000, d); chk("R10 unmapped 0x000", d, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule